// File: doc/BRIEF.md
# Cross-Lane Register Hazard Detector

Two in-order lanes split one instruction stream between them, and each lane issues its share without waiting for the other. One copy of this block sits in the issue stage of each lane. The block records, in a small table, the source registers of every local instruction that has read its operands and has not yet committed. It watches the write-back port of the opposite lane. A remote write-back can target a register that a younger local instruction has already read. That local instruction then consumed a stale value, and the block requests a replay that names it.

Each table row holds a sequence number and up to two source register IDs, and each source ID has its own valid bit. A row is freed when its instruction commits locally. A detected hazard or an external redirect empties the whole table. When several rows are hit by the same write-back, the replay names the oldest of them. Every younger row is discarded along with it, because the replay restarts from that point.

Top module: `xlane_hazard_det`

## Requirements
- R1: After reset the table is empty (`occupancy` = 0, `table_full` = 0) and `replay_req` is low.
- R2: An issue with `iss_valid` high takes one free row, which raises `occupancy` by one. When `table_full` is high (`occupancy` = ENTRIES), an issue is ignored and leaves no row behind.
- R3: A remote write-back hits a row when three conditions hold: its destination equals a source ID whose valid bit is set, the row is valid, and the write-back's sequence number is strictly older than the row's. On the next clock `replay_req` is high and `replay_seq` carries the row's sequence number.
- R4: A write-back whose sequence number is equal to or younger than the row's raises no replay.
- R5: A source slot whose valid bit is low never matches.
- R6: When several rows are hit in one cycle, `replay_seq` is the oldest of their sequence numbers.
- R7: A hit empties the table on the same clock edge. This includes an issue presented in the same cycle, which is dropped.
- R8: `flush` empties the table and raises no replay by itself.
- R9: A local commit whose `cmt_seq` equals a row's sequence number frees that row. A later write-back to its registers raises no replay.
- R10: Age comparison is modulo 2^SEQ_W. Sequence number a is older than b when bit SEQ_W-1 of (a - b) mod 2^SEQ_W is set.
- R11: A hit on a row whose commit is presented in the same cycle still raises the replay for that row.
- R12: `replay_req` is high for exactly the one cycle after each hitting write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | A local instruction read its operands this cycle |
| iss_seq | input | SEQ_W | Its sequence number |
| iss_src_a | input | REG_W | First source register ID |
| iss_src_a_vld | input | 1 | First source is used |
| iss_src_b | input | REG_W | Second source register ID |
| iss_src_b_vld | input | 1 | Second source is used |
| wb_valid | input | 1 | The other lane writes back this cycle |
| wb_seq | input | SEQ_W | Sequence number of that write-back |
| wb_dst | input | REG_W | Destination register of that write-back |
| cmt_valid | input | 1 | A local instruction commits this cycle |
| cmt_seq | input | SEQ_W | Sequence number of the committing instruction |
| flush | input | 1 | Redirect: empty the table |
| replay_req | output | 1 | Hazard found on the previous cycle |
| replay_seq | output | SEQ_W | Oldest offending sequence number |
| occupancy | output | $clog2(ENTRIES+1) | Number of valid rows |
| table_full | output | 1 | All rows are valid |

## Verification
A hazard can land in the same cycle as a local issue, or in the same cycle as the commit of the very row it hits. The bench drives both pairs together on one clock edge. For the first pair, it judges the result by the empty occupancy that follows and by a later write-back to the dropped issue's register, which must stay silent. For the second pair, it checks that the replay still names the committing row. A set of table rows is built so that some of its hits lie younger and some older than the write-back. The bench then checks that the reported sequence number is the oldest of the younger ones, with wrapped sequence numbers covered separately.

// File: rtl/depvd_pkg.sv
package depvd_pkg;
  // a is older than b when the modular difference a - b has its top bit set
  function automatic logic seq_older(logic [31:0] a, logic [31:0] b, int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/depvd_slot.sv
module depvd_slot #(
  parameter int SEQ_W = 8,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SEQ_W-1:0] ld_seq,
  input  logic [REG_W-1:0] ld_a,
  input  logic             ld_a_vld,
  input  logic [REG_W-1:0] ld_b,
  input  logic             ld_b_vld,
  input  logic             cmt_valid,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             wb_valid,
  input  logic [SEQ_W-1:0] wb_seq,
  input  logic [REG_W-1:0] wb_dst,
  output logic             vld,
  output logic [SEQ_W-1:0] seq,
  output logic             hit
);
  import depvd_pkg::*;

  logic [REG_W-1:0] src_a, src_b;
  logic             a_v, b_v;
  logic             reg_match, commit_me;

  assign reg_match = (a_v && src_a == wb_dst) || (b_v && src_b == wb_dst);
  assign hit       = vld && wb_valid && reg_match &&
                     seq_older(32'(wb_seq), 32'(seq), SEQ_W);
  assign commit_me = vld && cmt_valid && (cmt_seq == seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      seq   <= '0;
      src_a <= '0;
      src_b <= '0;
      a_v   <= 1'b0;
      b_v   <= 1'b0;
    end else if (clr) begin
      vld <= 1'b0;
    end else if (load) begin
      vld   <= 1'b1;
      seq   <= ld_seq;
      src_a <= ld_a;
      src_b <= ld_b;
      a_v   <= ld_a_vld;
      b_v   <= ld_b_vld;
    end else if (commit_me) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/depvd_pick_free.sv
module depvd_pick_free #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] grant_oh,
  output logic               any_free
);
  always_comb begin
    grant_oh = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!busy[i] && !any_free) begin
        grant_oh[i] = 1'b1;
        any_free    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/depvd_pick_oldest.sv
module depvd_pick_oldest #(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 8
) (
  input  logic [ENTRIES-1:0] hit,
  input  logic [SEQ_W-1:0]   seqs [ENTRIES],
  output logic               any_hit,
  output logic [SEQ_W-1:0]   oldest
);
  import depvd_pkg::*;

  always_comb begin
    any_hit = 1'b0;
    oldest  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && (!any_hit || seq_older(32'(seqs[i]), 32'(oldest), SEQ_W))) begin
        oldest  = seqs[i];
        any_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlane_hazard_det.sv
module xlane_hazard_det #(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 8,
  parameter int REG_W   = 5,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic [REG_W-1:0] iss_src_a,
  input  logic             iss_src_a_vld,
  input  logic [REG_W-1:0] iss_src_b,
  input  logic             iss_src_b_vld,
  input  logic             wb_valid,
  input  logic [SEQ_W-1:0] wb_seq,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             cmt_valid,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             flush,
  output logic             replay_req,
  output logic [SEQ_W-1:0] replay_seq,
  output logic [CNT_W-1:0] occupancy,
  output logic             table_full
);
  logic [ENTRIES-1:0] row_vld, row_hit, grant_oh, row_load;
  logic [SEQ_W-1:0]   row_seq [ENTRIES];
  logic               any_free, hazard, wipe, accept;
  logic [SEQ_W-1:0]   oldest_seq;

  assign wipe   = flush || hazard;
  assign accept = iss_valid && any_free && !wipe;

  depvd_pick_free #(.ENTRIES(ENTRIES)) u_free (
    .busy(row_vld), .grant_oh(grant_oh), .any_free(any_free)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    assign row_load[g] = accept && grant_oh[g];
    depvd_slot #(.SEQ_W(SEQ_W), .REG_W(REG_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(wipe), .load(row_load[g]),
      .ld_seq(iss_seq), .ld_a(iss_src_a), .ld_a_vld(iss_src_a_vld),
      .ld_b(iss_src_b), .ld_b_vld(iss_src_b_vld),
      .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
      .wb_valid(wb_valid), .wb_seq(wb_seq), .wb_dst(wb_dst),
      .vld(row_vld[g]), .seq(row_seq[g]), .hit(row_hit[g])
    );
  end

  depvd_pick_oldest #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_oldest (
    .hit(row_hit), .seqs(row_seq), .any_hit(hazard), .oldest(oldest_seq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replay_req <= 1'b0;
      replay_seq <= '0;
    end else begin
      replay_req <= hazard;
      if (hazard) replay_seq <= oldest_seq;
    end
  end

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < ENTRIES; i++) occupancy = occupancy + CNT_W'(row_vld[i]);
  end
  assign table_full = !any_free;
endmodule

// File: rtl/xlane_hazard_det_chk.sv
module xlane_hazard_det_chk #(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 8,
  parameter int REG_W   = 5,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             wb_valid,
  input logic [SEQ_W-1:0] wb_seq,
  input logic             flush,
  input logic             replay_req,
  input logic [SEQ_W-1:0] replay_seq,
  input logic [CNT_W-1:0] occupancy,
  input logic             table_full
);
  import depvd_pkg::*;

  // R12
  replay_needs_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> $past(wb_valid));

  // R7
  replay_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> occupancy == '0);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occupancy == '0);

  // R3
  replay_seq_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> seq_older(32'($past(wb_seq)), 32'(replay_seq), SEQ_W));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_full |=> occupancy <= CNT_W'(ENTRIES));

  // R2
  grow_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= $past(occupancy) + CNT_W'(1));
endmodule

bind xlane_hazard_det xlane_hazard_det_chk #(
  .ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .wb_valid(wb_valid),
  .wb_seq(wb_seq), .flush(flush), .replay_req(replay_req),
  .replay_seq(replay_seq), .occupancy(occupancy), .table_full(table_full)
);

// File: tb/xlane_hazard_det_bench.sv
module xlane_hazard_det_bench;
  localparam int ENTRIES = 8;
  localparam int SEQ_W   = 8;
  localparam int REG_W   = 5;
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 0, iss_src_a_vld = 0, iss_src_b_vld = 0;
  logic [SEQ_W-1:0] iss_seq = '0, wb_seq = '0, cmt_seq = '0;
  logic [REG_W-1:0] iss_src_a = '0, iss_src_b = '0, wb_dst = '0;
  logic wb_valid = 0, cmt_valid = 0, flush = 0;
  logic replay_req, table_full;
  logic [SEQ_W-1:0] replay_seq;
  logic [CNT_W-1:0] occupancy;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlane_hazard_det #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .REG_W(REG_W)) u_xlane_hazard_det (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .iss_src_a(iss_src_a), .iss_src_a_vld(iss_src_a_vld),
    .iss_src_b(iss_src_b), .iss_src_b_vld(iss_src_b_vld),
    .wb_valid(wb_valid), .wb_seq(wb_seq), .wb_dst(wb_dst),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .flush(flush),
    .replay_req(replay_req), .replay_seq(replay_seq),
    .occupancy(occupancy), .table_full(table_full)
  );

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [REG_W-1:0] a;
    logic             av;
    logic [REG_W-1:0] b;
    logic             bv;
    logic [SEQ_W-1:0] wseq;
    logic [REG_W-1:0] wdst;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd10, 5'd3, 1'b1, 5'd7, 1'b1, 8'd5,   5'd3},  // R3 first source
    '{8'd10, 5'd3, 1'b1, 5'd7, 1'b1, 8'd5,   5'd7},  // R3 second source
    '{8'd10, 5'd3, 1'b1, 5'd7, 1'b1, 8'd12,  5'd3},  // R4 younger writer
    '{8'd10, 5'd3, 1'b1, 5'd7, 1'b1, 8'd10,  5'd3},  // R4 same age
    '{8'd10, 5'd3, 1'b1, 5'd9, 1'b0, 8'd5,   5'd9},  // R5 unused slot
    '{8'd10, 5'd3, 1'b1, 5'd7, 1'b1, 8'd5,   5'd4},  // R3 other register
    '{8'd3,  5'd1, 1'b1, 5'd0, 1'b0, 8'd250, 5'd1},  // R10 wrapped older
    '{8'd250,5'd1, 1'b1, 5'd0, 1'b0, 8'd3,   5'd1}   // R10 wrapped younger
  };

  // own statement of age: the difference taken as a signed value is negative
  function automatic bit older_than(int a, int b);
    int d;
    d = (a - b) % 256;
    if (d < 0) d += 256;
    return d >= 128;
  endfunction

  function automatic bit expect_hit(vec_t v);
    bit m;
    m = (v.av && v.a == v.wdst) || (v.bv && v.b == v.wdst);
    return m && older_than(int'(v.wseq), int'(v.seq));
  endfunction

  task automatic tick();
    @(negedge clk);
    iss_valid = 0; iss_src_a_vld = 0; iss_src_b_vld = 0;
    wb_valid = 0; cmt_valid = 0; flush = 0;
  endtask

  task automatic set_issue(int s, int a, bit av, int b, bit bv);
    iss_valid = 1; iss_seq = SEQ_W'(s);
    iss_src_a = REG_W'(a); iss_src_a_vld = av;
    iss_src_b = REG_W'(b); iss_src_b_vld = bv;
  endtask

  task automatic set_wb(int s, int d);
    wb_valid = 1; wb_seq = SEQ_W'(s); wb_dst = REG_W'(d);
  endtask

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 full", int'(table_full), 0);
    chk("R1 replay", int'(replay_req), 0);
    rst_n = 1;
    @(negedge clk);

    // vector walk: R3 R4 R5 R10
    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      set_issue(int'(v.seq), int'(v.a), v.av, int'(v.b), v.bv);
      tick();
      set_wb(int'(v.wseq), int'(v.wdst));
      tick();
      chk($sformatf("R3/R4/R5/R10 vec %0d replay", i), int'(replay_req), int'(expect_hit(v)));
      if (expect_hit(v)) chk($sformatf("R3 vec %0d seq", i), int'(replay_seq), int'(v.seq));
      flush = 1;
      tick();
    end

    // R2 fill the table, odd rows also read register 31
    for (int i = 0; i < ENTRIES; i++) begin
      set_issue(20 + i, 10 + i, 1, 31, (i % 2) == 1);
      tick();
    end
    chk("R2 occupancy full", int'(occupancy), ENTRIES);
    chk("R2 full flag", int'(table_full), 1);
    set_issue(28, 30, 1, 0, 0);
    tick();
    chk("R2 ignored issue occupancy", int'(occupancy), ENTRIES);
    set_wb(1, 30);
    tick();
    chk("R2 ignored issue no replay", int'(replay_req), 0);

    // R6 hits on 23, 25, 27 (21 is older than writer 22)
    set_wb(22, 31);
    tick();
    chk("R6 replay", int'(replay_req), 1);
    chk("R6 oldest seq", int'(replay_seq), 23);
    chk("R7 emptied", int'(occupancy), 0);
    tick();
    chk("R12 single pulse", int'(replay_req), 0);

    // R7 hazard with a same-cycle issue
    set_issue(40, 2, 1, 0, 0);
    tick();
    set_wb(35, 2);
    set_issue(41, 6, 1, 0, 0);
    tick();
    chk("R7 replay", int'(replay_req), 1);
    chk("R7 issue dropped occupancy", int'(occupancy), 0);
    set_wb(30, 6);
    tick();
    chk("R7 dropped issue silent", int'(replay_req), 0);

    // R8 flush
    set_issue(50, 4, 1, 0, 0);
    tick();
    flush = 1;
    tick();
    chk("R8 occupancy", int'(occupancy), 0);
    chk("R8 no replay", int'(replay_req), 0);
    set_wb(45, 4);
    tick();
    chk("R8 flushed row silent", int'(replay_req), 0);

    // R9 commit frees only the matching row
    set_issue(60, 8, 1, 0, 0);
    tick();
    set_issue(61, 9, 1, 0, 0);
    tick();
    cmt_valid = 1; cmt_seq = 8'd60;
    tick();
    chk("R9 occupancy", int'(occupancy), 1);
    set_wb(55, 8);
    tick();
    chk("R9 committed row silent", int'(replay_req), 0);
    set_wb(55, 9);
    tick();
    chk("R9 other row replay", int'(replay_req), 1);
    chk("R9 other row seq", int'(replay_seq), 61);

    // R11 hazard and commit of the same row together
    set_issue(70, 12, 1, 0, 0);
    tick();
    set_wb(65, 12);
    cmt_valid = 1; cmt_seq = 8'd70;
    tick();
    chk("R11 replay", int'(replay_req), 1);
    chk("R11 seq", int'(replay_seq), 70);
    chk("R11 occupancy", int'(occupancy), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule